// File: doc/BRIEF.md
# Multiplexed Address/Data Read Controller

This block runs asynchronous read cycles to an external byte-wide memory that shares one 16-bit pad group for address and data. The low byte of the pads carries the low address first and the returned data later; the high byte carries the upper address for the whole access. An external transparent latch, opened by an address latch enable strobe, keeps the low address byte once the controller lets go of the low pads.

A client presents a 16-bit address with a valid flag. The controller takes it only when idle, and signals this with a ready output. It then steps through a fixed sequence, all in core clock cycles:

- one cycle of address setup;
- two cycles of latch enable;
- one turnaround cycle in which the low pads float;
- a read strobe of programmable length;
- one cycle in which the upper address is still driven;
- an optional extra hold cycle.

The byte on the low pads is captured as the strobe ends. It is handed back with a one-cycle done pulse.

A small control register, written through a write-enable port, sets three things: the strobe length, whether the hold cycle is added, and the polarity of the latch enable pin. The length and hold settings are sampled when a request is accepted, so rewriting the register mid-access only affects later accesses.

Top module: `mux_rd_ctrl`

## Requirements
- R1: While reset is asserted and at the first cycles after it, `req_ready`=1, `done`=0, `rd_n_o`=1, `wr_n_o`=1, `ale_o`=0, `ad_lo_oe`=0 and `ad_hi_oe`=0; an asynchronous reset in the middle of an access returns to this state at once.
- R2: A request is accepted at a clock edge where `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the next cycle until the done cycle. A request held valid while busy is ignored and does not alter the address on the pads.
- R3: Counting the cycle after the accepting edge as cycle 0, the full address is driven (`ad_lo_oe`=`ad_hi_oe`=1) in cycles 0 to 2, and the latch enable is active in cycles 1 and 2 only.
- R4: `ad_lo_oe` is 0 from cycle 3, the cycle in which the latch enable goes inactive, until the access ends.
- R5: `rd_n_o` is low in cycles 4 to 3+D and high at all other times. D is control bits 5:1, and a value of 0 is taken as 1.
- R6: `ad_hi_oe` stays 1 with the upper address byte through the strobe and for cycle 4+D. When control bit 0 is 1 it also stays 1 for cycle 5+D.
- R7: The byte on `ad_lo_i` during the last strobe cycle (3+D) is captured as `rd_n_o` rises. It is shown on `rd_data` in the done cycle, whatever `ad_lo_i` does afterwards.
- R8: `done` is a single-cycle pulse in cycle 5+D+H, where H is the sampled control bit 0. `req_ready` is 1 again in that cycle.
- R9: Control bit 6 selects the latch enable polarity: 0 means active high, 1 means active low, and the inactive level is driven while idle. The reset value of the bit is 0.
- R10: `wr_n_o` is never driven low.
- R11: D and the hold bit are sampled when a request is accepted. A control write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 16 | Read address |
| req_ready | output | 1 | Controller idle, can accept a request |
| done | output | 1 | One-cycle pulse, read complete |
| rd_data | output | 8 | Captured data byte |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control write data: bit 0 hold, bits 5:1 strobe length, bit 6 latch polarity |
| ale_o | output | 1 | Address latch enable pin |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low, held high |
| ad_lo_o | output | 8 | Low pad byte output value |
| ad_lo_oe | output | 1 | Low pad byte output enable |
| ad_lo_i | input | 8 | Low pad byte input value |
| ad_hi_o | output | 8 | High pad byte output value |
| ad_hi_oe | output | 1 | High pad byte output enable |

## Verification
Every pad output is a decode of the registered phase. Each one therefore changes on the clock edge that starts its cycle: latch enable in cycles 1 to 2, read strobe in cycles 4 to 3+D, done in cycle 5+D+H. The bench counts cycles from the accepting edge and samples every output at the falling edge of each cycle of the access, including one idle cycle after it. It applies the valid data only in cycle 3+D and drives different values before and after. This shows that the capture happens exactly at the strobe's rising edge. Control writes take effect one edge after `ctl_we`, and the bench drives them a full cycle before the request they are meant to shape.

// File: rtl/mux_rd_pkg.sv
package mux_rd_pkg;

  // control register layout; bit positions are software-visible
  localparam int CTL_W    = 8;
  localparam int HOLD_BIT = 0;
  localparam int LEN_LSB  = 1;
  localparam int LEN_W    = 5;
  localparam int POL_BIT  = 6;

  // number of core cycles the address latch enable is active
  localparam int ALE_CYC  = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LATCH,
    PH_GAP,
    PH_STROBE,
    PH_TAIL,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic             ale_low;
    logic [LEN_W-1:0] len;
    logic             hold_en;
  } ctl_t;

endpackage

// File: rtl/mux_rd_rstsync.sv
module mux_rd_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mux_rd_ctlreg.sv
module mux_rd_ctlreg
  import mux_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);

  ctl_t ctl_q;
  ctl_t ctl_d;

  // next-state: unpack the written word into named fields
  always_comb begin
    ctl_d         = ctl_q;
    ctl_d.hold_en = wdata[HOLD_BIT];
    ctl_d.len     = wdata[LEN_LSB +: LEN_W];
    ctl_d.ale_low = wdata[POL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
  import mux_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] ad_lo_i,
  output phase_e            phase,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              done
);

  localparam logic [LEN_W-1:0] LATCH_LAST = LEN_W'(ALE_CYC - 1);
  localparam logic [LEN_W-1:0] LEN_MIN    = LEN_W'(1);

  phase_e            ph_q, ph_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q;
  logic              hold_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;

  logic              accept;
  logic              cap_en;
  logic [LEN_W-1:0]  len_eff;

  assign accept  = req_valid && (ph_q == PH_IDLE);
  assign len_eff = (ctl.len == '0) ? LEN_MIN : ctl.len;
  assign cap_en  = (ph_q == PH_STROBE) && (cnt_q == '0);

  // next-state logic
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) ph_d = PH_SETUP;
      end
      PH_SETUP: begin
        ph_d  = PH_LATCH;
        cnt_d = LATCH_LAST;
      end
      PH_LATCH: begin
        if (cnt_q == '0) ph_d = PH_GAP;
        else             cnt_d = cnt_q - 1'b1;
      end
      PH_GAP: begin
        ph_d  = PH_STROBE;
        cnt_d = len_q - 1'b1;
      end
      PH_STROBE: begin
        if (cnt_q == '0) ph_d = PH_TAIL;
        else             cnt_d = cnt_q - 1'b1;
      end
      PH_TAIL: begin
        if (hold_q) begin
          ph_d = PH_HOLD;
        end else begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      PH_HOLD: begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // request snapshot, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= LEN_MIN;
      hold_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      len_q  <= len_eff;
      hold_q <= ctl.hold_en;
    end
  end

  // data capture on the edge that ends the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= ad_lo_i;
    end
  end

  assign phase = ph_q;
  assign addr  = addr_q;
  assign data  = data_q;
  assign ready = (ph_q == PH_IDLE);
  assign done  = done_q;

endmodule

// File: rtl/mux_rd_pads.sv
module mux_rd_pads
  import mux_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  phase_e                   phase,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ale_low,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_lo_o,
  output logic                     ad_lo_oe,
  output logic [ADDR_W-DATA_W-1:0] ad_hi_o,
  output logic                     ad_hi_oe
);

  logic ale_act;

  always_comb begin
    ale_act  = 1'b0;
    rd_n_o   = 1'b1;
    ad_lo_oe = 1'b0;
    ad_hi_oe = 1'b0;
    unique case (phase)
      PH_SETUP: begin
        ad_lo_oe = 1'b1;
        ad_hi_oe = 1'b1;
      end
      PH_LATCH: begin
        ale_act  = 1'b1;
        ad_lo_oe = 1'b1;
        ad_hi_oe = 1'b1;
      end
      PH_GAP, PH_TAIL, PH_HOLD: begin
        ad_hi_oe = 1'b1;
      end
      PH_STROBE: begin
        rd_n_o   = 1'b0;
        ad_hi_oe = 1'b1;
      end
      default: begin
        ale_act = 1'b0;
      end
    endcase
  end

  assign ale_o   = ale_act ^ ale_low;
  assign wr_n_o  = 1'b1;
  assign ad_lo_o = ad_lo_oe ? addr[DATA_W-1:0]      : '0;
  assign ad_hi_o = ad_hi_oe ? addr[ADDR_W-1:DATA_W] : '0;

endmodule

// File: rtl/mux_rd_ctrl.sv
module mux_rd_ctrl
  import mux_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     ctl_we,
  input  logic [CTL_W-1:0]         ctl_wdata,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_lo_o,
  output logic                     ad_lo_oe,
  input  logic [DATA_W-1:0]        ad_lo_i,
  output logic [ADDR_W-DATA_W-1:0] ad_hi_o,
  output logic                     ad_hi_oe
);

  logic              rst_sync_n;
  ctl_t              ctl;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic              ale_low_w;

  assign ale_low_w = ctl.ale_low;

  mux_rd_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mux_rd_ctlreg u_ctl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  mux_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .ctl       (ctl),
    .ad_lo_i   (ad_lo_i),
    .phase     (phase),
    .addr      (addr_q),
    .data      (rd_data),
    .ready     (req_ready),
    .done      (done)
  );

  mux_rd_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
    .phase    (phase),
    .addr     (addr_q),
    .ale_low  (ale_low_w),
    .ale_o    (ale_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .ad_lo_o  (ad_lo_o),
    .ad_lo_oe (ad_lo_oe),
    .ad_hi_o  (ad_hi_o),
    .ad_hi_oe (ad_hi_oe)
  );

endmodule

// File: rtl/mux_rd_ctrl_chk.sv
module mux_rd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic ale_o,
  input logic ale_low,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic ad_lo_oe,
  input logic ad_hi_oe
);

  // R10
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n_o);

  // R4
  lo_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_lo_oe);

  // R6
  hi_during_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> ad_hi_oe);

  // R6
  hi_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_o) |-> ad_hi_oe);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R5
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n_o) |-> ($past(ale_o) == ale_low) && ($past(ale_o, 2) != ale_low));

  // R3
  ale_quiet_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> (ale_o == ale_low));

endmodule

bind mux_rd_ctrl mux_rd_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .ale_o     (ale_o),
  .ale_low   (ale_low_w),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .ad_lo_oe  (ad_lo_oe),
  .ad_hi_oe  (ad_hi_oe)
);

// File: tb/mux_rd_ctrl_bench.sv
module mux_rd_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        req_ready;
  logic        done;
  logic [7:0]  rd_data;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic        ale_o;
  logic        rd_n_o;
  logic        wr_n_o;
  logic [7:0]  ad_lo_o;
  logic        ad_lo_oe;
  logic [7:0]  ad_lo_i;
  logic [7:0]  ad_hi_o;
  logic        ad_hi_oe;

  int errors = 0;
  int checks = 0;
  logic [7:0] cur_ctl;

  mux_rd_ctrl u_mux_rd_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .done      (done),
    .rd_data   (rd_data),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .ad_lo_o   (ad_lo_o),
    .ad_lo_oe  (ad_lo_oe),
    .ad_lo_i   (ad_lo_i),
    .ad_hi_o   (ad_hi_o),
    .ad_hi_oe  (ad_hi_oe)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {address, control word, memory data}
  localparam logic [31:0] VEC [6] = '{
    {16'hA55A, 8'h00, 8'h3C},
    {16'h1234, 8'h03, 8'hC3},
    {16'hFF00, 8'h46, 8'h81},
    {16'h00FF, 8'h3F, 8'h7E},
    {16'h8001, 8'h49, 8'h5A},
    {16'h0F0F, 8'h0A, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {15'd0, req_ready}, 16'd1);
    chk(tag, {15'd0, done},      16'd0);
    chk(tag, {15'd0, rd_n_o},    16'd1);
    chk(tag, {15'd0, wr_n_o},    16'd1);
    chk(tag, {15'd0, ale_o},     16'd0);
    chk(tag, {15'd0, ad_lo_oe},  16'd0);
    chk(tag, {15'd0, ad_hi_oe},  16'd0);
  endtask

  task automatic write_ctl(input logic [7:0] val);
    ctl_we    = 1'b1;
    ctl_wdata = val;
    @(negedge clk);
    ctl_we    = 1'b0;
    cur_ctl   = val;
  endtask

  // Runs one read; caller is at a falling edge. Cycle k counts edges after acceptance.
  task automatic run_txn(input logic [15:0] addr, input logic [7:0] data,
                         input bit busy_req, input bit mid_wr, input logic [7:0] mid_ctl);
    int d;
    int h;
    int last;
    logic pol;
    d    = (cur_ctl[5:1] == 5'd0) ? 1 : int'(cur_ctl[5:1]);
    h    = int'(cur_ctl[0]);
    pol  = cur_ctl[6];
    last = 5 + d + h;
    chk("R2 ready before request", {15'd0, req_ready}, 16'd1);
    req_valid = 1'b1;
    req_addr  = addr;
    ad_lo_i   = ~data;
    @(negedge clk);
    for (int k = 0; k <= last + 1; k++) begin
      if (k == 0) begin
        if (busy_req) req_addr = ~addr;
        else          req_valid = 1'b0;
        if (mid_wr) begin
          ctl_we    = 1'b1;
          ctl_wdata = mid_ctl;
        end
      end
      if (k == 1 && mid_wr) begin
        ctl_we  = 1'b0;
        cur_ctl = mid_ctl;
      end
      if (busy_req && k == last - 1) req_valid = 1'b0;
      if (k == 3 + d)                    ad_lo_i = data;
      else if (k >= 4 && k < 3 + d)      ad_lo_i = data ^ 8'h5A;
      else                               ad_lo_i = ~data;

      chk(pol ? "R9 ale level" : "R3 ale level", {15'd0, ale_o},
          {15'd0, ((k == 1 || k == 2) ? 1'b1 : 1'b0) ^ pol});
      chk("R4 low pad enable", {15'd0, ad_lo_oe}, {15'd0, (k <= 2) ? 1'b1 : 1'b0});
      if (k <= 2) chk("R3 address on pads", {ad_hi_o, ad_lo_o}, addr);
      chk("R6 high pad enable", {15'd0, ad_hi_oe}, {15'd0, (k <= 4 + d + h) ? 1'b1 : 1'b0});
      if (k >= 3 && k <= 4 + d + h) chk("R6 upper address held", {8'd0, ad_hi_o}, {8'd0, addr[15:8]});
      chk("R5 read strobe", {15'd0, rd_n_o}, {15'd0, (k >= 4 && k <= 3 + d) ? 1'b0 : 1'b1});
      chk("R10 write strobe", {15'd0, wr_n_o}, 16'd1);
      chk("R8 done pulse", {15'd0, done}, {15'd0, (k == last) ? 1'b1 : 1'b0});
      chk("R2 ready while busy", {15'd0, req_ready}, {15'd0, (k >= last) ? 1'b1 : 1'b0});
      if (k == last) chk("R7 captured byte", {8'd0, rd_data}, {8'd0, data});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    ctl_we    = 1'b0;
    ctl_wdata = '0;
    ad_lo_i   = '0;
    cur_ctl   = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after reset");

    // table-driven accesses: strobe lengths 0..31, hold on/off, both polarities
    for (int i = 0; i < 6; i++) begin
      write_ctl(VEC[i][15:8]);
      run_txn(VEC[i][31:16], VEC[i][7:0], 1'b0, 1'b0, 8'h00);
    end

    // R9: active-low latch enable idles high
    write_ctl(8'h44);
    chk("R9 idle level active-low", {15'd0, ale_o}, 16'd1);

    // R2: request held valid through a busy access
    write_ctl(8'h05);
    run_txn(16'hC0DE, 8'hE7, 1'b1, 1'b0, 8'h00);

    // R11: control rewrite during an access, then the next access uses it
    write_ctl(8'h04);
    run_txn(16'h2468, 8'h11, 1'b0, 1'b1, 8'h0B);
    run_txn(16'h1357, 8'h99, 1'b0, 1'b0, 8'h00);

    // R1, R9: reset mid-access with active-low polarity selected
    write_ctl(8'h48);
    req_valid = 1'b1;
    req_addr  = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid-access");
    chk("R9 polarity reset value", {15'd0, ale_o}, 16'd0);
    @(negedge clk);
    rst_n   = 1'b1;
    cur_ctl = 8'h00;
    repeat (4) @(negedge clk);
    chk_idle("R1 recovered");
    run_txn(16'h7E81, 8'hA5, 1'b0, 1'b0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule